// File: doc/BRIEF.md
# Sixteen-Register Word Processor Core

This block is a small multi-cycle processor. It has a 16-bit datapath, sixteen 16-bit general registers and a unified store of 256 words of 16 bits that holds both instructions and data. Every instruction is one 16-bit word and selects one of sixteen operations. Each instruction takes a fetch cycle and an execute cycle. The execute cycle is extended only while a stream transfer waits for its partner.

A word address, by default 0xFF, is not backed by storage for data accesses. A load from that address takes a word from an input stream with a valid/ready handshake. A store to that address hands a word to an output stream with a valid/ready handshake. To load a program, hold the core in reset and write words through the load port. Then release reset and execution begins at the configured start address. When the core executes a halt, it raises `halted` and stays stopped until the next reset.

Top module: `word16_core`

## Requirements
- R1: While `rst_n` is low, `halted`, `in_ready` and `out_valid` are low, and all registers and the program counter reset. After release, the first instruction is fetched from address `START_PC` (default 0x10).
- R2: The instruction fields are fixed. Opcode = bits [15:12], destination d = [11:8], source s = [7:4], source t = [3:0]. The 8-bit address or immediate field is [7:0].
- R3: Opcodes 1..6 write R[d] = R[s] op R[t], where op is add, subtract, AND, XOR, shift left or logical shift right, in that order. Add and subtract wrap modulo 2^16. A shift moves by the low 4 bits of R[t].
- R4: Register 0 always reads as zero, and any write to it is discarded.
- R5: Opcode 7 writes the zero-extended 8-bit immediate into R[d]. Opcode 8 loads R[d] from the word at the 8-bit address. Opcode 9 stores R[d] to that address.
- R6: Opcode A loads R[d] from the word addressed by the low 8 bits of R[t]. Opcode B stores R[d] there.
- R7: Opcode C jumps to the 8-bit address when R[d] is zero. Opcode D jumps there when R[d], read as a signed two's-complement value, is greater than zero. Otherwise execution falls through.
- R8: Opcode E jumps to the low 8 bits of R[d]. Opcode F writes the address of the following instruction into R[d] and then jumps to the 8-bit address.
- R9: A load whose effective address is `IO_ADDR` raises `in_ready` and waits until `in_valid` is high. On the handshake cycle it writes `in_data` into R[d]. `in_ready` is low at all other times.
- R10: A store whose effective address is `IO_ADDR` raises `out_valid` with `out_data` = R[d]. Both stay unchanged until `out_ready` completes the transfer. No storage word is changed by that store.
- R11: Opcode 0 raises `halted`. The core then stays stopped, with no stream activity, until reset.
- R12: `load_we` writes `load_data` to `load_addr` only while `rst_n` is low. While the core runs, the load port is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; load window |
| load_we | input | 1 | Program/data write strobe (reset only) |
| load_addr | input | 8 | Word address for the load port |
| load_data | input | 16 | Word written by the load port |
| in_data | input | 16 | Input stream word |
| in_valid | input | 1 | Input stream word available |
| in_ready | output | 1 | Core is taking an input word |
| out_data | output | 16 | Output stream word |
| out_valid | output | 1 | Output stream word available |
| out_ready | input | 1 | Consumer accepts the output word |
| halted | output | 1 | Core has executed a halt |

## Verification
The hardest case to reach from the ports is a load-port write that arrives while the core is running. It must leave storage untouched, and that can only be seen when a later instruction reads the same word back. The bench runs a program that stalls on an input load. During the stall it drives a write to a preloaded data word. It then releases the input and expects the program to output the original word. Random vectors feed 16-bit operands through the input stream under random valid/ready throttling, so stalls hit both loads and stores. Their register choices sometimes land on register 0 as a source or destination.

// File: rtl/word16_core.sv
module word16_core #(
  parameter logic [7:0] START_PC = 8'h10,
  parameter logic [7:0] IO_ADDR  = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_we,
  input  logic [7:0]  load_addr,
  input  logic [15:0] load_data,
  input  logic [15:0] in_data,
  input  logic        in_valid,
  output logic        in_ready,
  output logic [15:0] out_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        halted
);

  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_HALT} phase_t;

  phase_t      phase;
  logic [7:0]  pc;
  logic [15:0] ir;
  logic [15:0] rf   [16];
  logic [15:0] mem  [256];

  logic [3:0]  op, rd, rs, rt;
  logic [7:0]  imm, ea;
  logic [15:0] rd_v, rs_v, rt_v, alu_v, wb_v;
  logic        exec, is_ld, is_st, at_io, stall, wb_en, mem_we;
  logic [7:0]  pc_nxt;

  assign op  = ir[15:12];
  assign rd  = ir[11:8];
  assign rs  = ir[7:4];
  assign rt  = ir[3:0];
  assign imm = ir[7:0];

  assign rd_v = (rd == 4'd0) ? 16'd0 : rf[rd];
  assign rs_v = (rs == 4'd0) ? 16'd0 : rf[rs];
  assign rt_v = (rt == 4'd0) ? 16'd0 : rf[rt];

  assign exec  = (phase == S_EXEC);
  assign is_ld = (op == 4'h8) || (op == 4'hA);
  assign is_st = (op == 4'h9) || (op == 4'hB);
  assign ea    = (op == 4'hA || op == 4'hB) ? rt_v[7:0] : imm;
  assign at_io = (ea == IO_ADDR);

  assign in_ready  = exec && is_ld && at_io;
  assign out_valid = exec && is_st && at_io;
  assign out_data  = rd_v;
  assign halted    = (phase == S_HALT);

  assign stall  = (in_ready && !in_valid) || (out_valid && !out_ready);
  assign mem_we = exec && is_st && !at_io;

  always_comb begin
    case (op)
      4'h1:    alu_v = rs_v + rt_v;
      4'h2:    alu_v = rs_v - rt_v;
      4'h3:    alu_v = rs_v & rt_v;
      4'h4:    alu_v = rs_v ^ rt_v;
      4'h5:    alu_v = rs_v << rt_v[3:0];
      4'h6:    alu_v = rs_v >> rt_v[3:0];
      default: alu_v = 16'd0;
    endcase
  end

  always_comb begin
    wb_en = 1'b0;
    wb_v  = alu_v;
    case (op)
      4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6: wb_en = 1'b1;
      4'h7: begin wb_en = 1'b1; wb_v = {8'd0, imm}; end
      4'h8, 4'hA: begin wb_en = 1'b1; wb_v = at_io ? in_data : mem[ea]; end
      4'hF: begin wb_en = 1'b1; wb_v = {8'd0, pc}; end
      default: wb_en = 1'b0;
    endcase
    wb_en = wb_en && exec && !stall && (rd != 4'd0);
  end

  always_comb begin
    pc_nxt = pc;
    case (op)
      4'hC: if (rd_v == 16'd0) pc_nxt = imm;
      4'hD: if ($signed(rd_v) > 16'sd0) pc_nxt = imm;
      4'hE: pc_nxt = rd_v[7:0];
      4'hF: pc_nxt = imm;
      default: pc_nxt = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= S_FETCH;
      pc    <= START_PC;
      ir    <= 16'd0;
      for (int i = 0; i < 16; i++) rf[i] <= 16'd0;
    end else begin
      case (phase)
        S_FETCH: begin
          ir    <= mem[pc];
          pc    <= pc + 8'd1;
          phase <= S_EXEC;
        end
        S_EXEC: begin
          if (op == 4'h0) begin
            phase <= S_HALT;
          end else if (!stall) begin
            pc    <= pc_nxt;
            phase <= S_FETCH;
          end
          if (wb_en) rf[rd] <= wb_v;
        end
        default: phase <= S_HALT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (load_we) mem[load_addr] <= load_data;
    end else if (mem_we) begin
      mem[ea] <= rd_v;
    end
  end

  // R11
  halt_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(pc));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R9
  in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && !in_valid |=> in_ready);

  // R9
  io_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R8
  link_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == 4'hF |=> pc == $past(imm));

  // R2
  fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == S_FETCH |=> exec && pc == $past(pc) + 8'd1);

endmodule

// File: tb/tb_word16_core.sv
`timescale 1ns/1ps
module tb_word16_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_we = 1'b0;
  logic [7:0]  load_addr = 8'd0;
  logic [15:0] load_data = 16'd0;
  logic [15:0] in_data = 16'd0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] out_data;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        halted;

  int vecs = 0;
  int fails = 0;
  logic [15:0] in_q  [8];
  logic [15:0] exp_q [8];

  always #2.5 clk = ~clk;

  word16_core dut (
    .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_addr(load_addr),
    .load_data(load_data), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .halted(halted)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
    vecs++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] alu_ref(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
    case (op)
      4'h1: return a + b;
      4'h2: return a - b;
      4'h3: return a & b;
      4'h4: return a ^ b;
      4'h5: return a << b[3:0];
      4'h6: return a >> b[3:0];
      default: return 16'd0;
    endcase
  endfunction

  task automatic enter_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    load_we = 1'b1; load_addr = a; load_data = d;
    @(negedge clk);
    load_we = 1'b0;
  endtask

  task automatic run(input int n_in, input int n_out, input string req);
    int ii = 0;
    int oo = 0;
    int cyc = 0;
    rst_n = 1'b1;
    while (!halted && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      in_valid  = (ii < n_in) && ($urandom % 4 != 0);
      in_data   = in_q[ii % 8];
      out_ready = ($urandom % 4 != 0);
      if (in_valid && in_ready) ii++;
      if (out_valid && out_ready) begin
        if (oo < n_out) chk(req, out_data, exp_q[oo]);
        else chk({req, " extra output"}, out_data, 16'hxxxx);
        oo++;
      end
    end
    in_valid = 1'b0; out_ready = 1'b0;
    if (cyc >= 3000) begin
      fails++;
      $display("FAIL %s: program did not halt, got running expected halted", req);
    end
    chk({req, " output count"}, 16'(oo), 16'(n_out));
    chk({req, " input count"}, 16'(ii), 16'(n_in));
  endtask

  task automatic alu_vec(input logic [3:0] op, input logic [3:0] s, input logic [3:0] t,
                         input logic [3:0] d, input logic [15:0] a, input logic [15:0] b);
    logic [15:0] av;
    logic [15:0] e;
    enter_reset();
    poke(8'h10, {4'h8, s, 8'hFF});
    poke(8'h11, {4'h8, t, 8'hFF});
    poke(8'h12, {op, d, s, t});
    poke(8'h13, {4'h9, d, 8'hFF});
    poke(8'h14, 16'h0000);
    in_q[0] = a; in_q[1] = b;
    av = (s == 4'd0) ? 16'd0 : a;
    e  = (d == 4'd0) ? 16'd0 : alu_ref(op, av, b);
    exp_q[0] = e;
    run(2, 1, (s == 4'd0 || d == 4'd0) ? "R4 zero register" : "R3 alu");
  endtask

  initial begin
    void'($urandom(32'd2024));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 halted in reset", {15'd0, halted}, 16'd0);
    chk("R1 in_ready in reset", {15'd0, in_ready}, 16'd0);
    chk("R1 out_valid in reset", {15'd0, out_valid}, 16'd0);

    // R5 R6 R7 R9 R10: input copy loop, indirect store/load, zero branch
    enter_reset();
    poke(8'h10, 16'h7101); poke(8'h11, 16'h7A40); poke(8'h12, 16'h7C00);
    poke(8'h13, 16'h8DFF); poke(8'h14, 16'hCD19); poke(8'h15, 16'h12AC);
    poke(8'h16, 16'hBD02); poke(8'h17, 16'h1CC1); poke(8'h18, 16'hC013);
    poke(8'h19, 16'hA30A); poke(8'h1A, 16'h93FF); poke(8'h1B, 16'h8341);
    poke(8'h1C, 16'h93FF); poke(8'h1D, 16'h9CFF); poke(8'h1E, 16'h0000);
    in_q[0] = 16'h1234; in_q[1] = 16'hBEEF; in_q[2] = 16'h0000;
    exp_q[0] = 16'h1234; exp_q[1] = 16'hBEEF; exp_q[2] = 16'h0002;
    run(3, 3, "R6 R7 R9 R10 copy loop");

    // R7 R8 R4: signed branch, link/return, writes to R0 discarded
    for (int k = 0; k < 3; k++) begin
      enter_reset();
      poke(8'h10, 16'h81FF); poke(8'h11, 16'hD114); poke(8'h12, 16'h7255);
      poke(8'h13, 16'hC015); poke(8'h14, 16'h72AA); poke(8'h15, 16'h92FF);
      poke(8'h16, 16'hF320); poke(8'h17, 16'h93FF); poke(8'h18, 16'h0000);
      poke(8'h20, 16'h7099); poke(8'h21, 16'h90FF); poke(8'h22, 16'hE300);
      in_q[0] = (k == 0) ? 16'h8000 : (k == 1) ? 16'h0001 : 16'h0000;
      exp_q[0] = (k == 1) ? 16'h00AA : 16'h0055;
      exp_q[1] = 16'h0000;
      exp_q[2] = 16'h0017;
      run(1, 3, "R7 R8 R4 branch/link");
    end

    // R12 R11 R5: load port ignored while running, then halt holds
    enter_reset();
    poke(8'h10, 16'h81FF); poke(8'h11, 16'h8230);
    poke(8'h12, 16'h92FF); poke(8'h13, 16'h0000);
    poke(8'h30, 16'h5A5A);
    rst_n = 1'b1;
    for (int c = 0; c < 20 && !in_ready; c++) @(negedge clk);
    chk("R9 stalled load asserts in_ready", {15'd0, in_ready}, 16'd1);
    load_we = 1'b1; load_addr = 8'h30; load_data = 16'hDEAD;
    @(negedge clk);
    load_we = 1'b0;
    chk("R9 in_ready held while no input", {15'd0, in_ready}, 16'd1);
    in_q[0] = 16'h0007; exp_q[0] = 16'h5A5A;
    run(1, 1, "R12 load port ignored");
    for (int c = 0; c < 10; c++) @(negedge clk);
    chk("R11 halted stays high", {15'd0, halted}, 16'd1);
    chk("R11 no output after halt", {15'd0, out_valid}, 16'd0);
    chk("R11 no input after halt", {15'd0, in_ready}, 16'd0);

    // R3 directed corners
    alu_vec(4'h5, 4'h1, 4'h2, 4'h3, 16'h0001, 16'h000F);
    alu_vec(4'h6, 4'h1, 4'h2, 4'h3, 16'h8000, 16'h000F);
    alu_vec(4'h5, 4'h1, 4'h2, 4'h3, 16'h00FF, 16'h0014);
    alu_vec(4'h2, 4'h1, 4'h2, 4'h3, 16'h0000, 16'h0001);
    alu_vec(4'h1, 4'h1, 4'h2, 4'h3, 16'hFFFF, 16'h0002);

    // R3 R4 random vectors
    for (int n = 0; n < 40; n++) begin
      logic [3:0] s, t, d, op;
      s  = 4'($urandom % 16);
      t  = 4'(1 + $urandom % 15);
      if (t == s) t = (s == 4'd15) ? 4'd1 : s + 4'd1;
      d  = 4'($urandom % 16);
      op = 4'(1 + $urandom % 6);
      alu_vec(op, s, t, d, 16'($urandom), ($urandom % 2) ? 16'($urandom % 20) : 16'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule